// File: doc/BRIEF.md
# Mean-Square Window Accumulator

This block condenses a stream of signed 16-bit fixed-point vibration samples into one energy figure per window. Each accepted sample is squared, and the squares are summed in a 32-bit accumulator. After the window's 256th sample, the sum is divided by the window length. The window length is a power of two, so the division is a plain right shift by 8. The result is presented together with a one-cycle valid strobe. No square root is taken, because the mean of squares already ranks signal energy.

Each result is also compared with a programmable reference level, which is the figure recorded for a healthy machine. A result strictly above that level raises a fault indication that travels with the result. Windows follow one another without a gap: the first sample of a window replaces the accumulator contents instead of adding to them. If the sum would pass the top of the accumulator, it is clamped there, and a sticky overflow flag records that it happened.

Top module: `msq_window_acc`

## Requirements
- R1: While reset is asserted, `smp_ready`, `res_valid`, `res_fault` and `ovf_flag` are 0, `res_level` is 0 and the reference level is 0.
- R2: After reset is released, `smp_ready` goes to 1. A sample counts only in a cycle where both `smp_valid` and `smp_ready` are 1. Cycles with `smp_valid` low neither advance nor alter the window, whatever `smp_data` holds.
- R3: When the 256th accepted sample of a window is taken at a rising edge, `res_valid` is 1 for exactly the following clock cycle. In that cycle `res_level` equals (sum of the 256 squares) shifted right by 8. `res_level` keeps that value until the next result.
- R4: A window may start in the cycle right after the previous window's last sample. Its result depends only on its own 256 samples.
- R5: The running sum saturates at 0xFFFFFFFF instead of wrapping. A clamped window therefore reports 0x00FFFFFF.
- R6: `ovf_flag` goes to 1 when the sum is clamped and stays at 1 until reset.
- R7: `res_fault` is 1 exactly when the latest `res_level` is strictly greater than the reference level in force for that window. The value is updated together with `res_level`, and a result equal to the reference gives 0.
- R8: A value on `ref_level` is stored in a cycle where `ref_we` is 1. A window uses the value stored most recently before the cycle in which its first sample is accepted. A write made during a window therefore applies only from the next window on.
- R9: Asserting reset in the middle of a window discards the partial sum. The next window after release starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_ready | output | 1 | Block can take a sample (1 whenever out of reset) |
| smp_data | input | 16 | Signed two's-complement sample |
| ref_we | input | 1 | Store `ref_level` as the pending reference |
| ref_level | input | 32 | Reference level for a healthy machine |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_level | output | 32 | Mean of squares of the last complete window |
| res_fault | output | 1 | Last result exceeded its reference |
| ovf_flag | output | 1 | Sticky: the accumulator has been clamped |

## Verification
Two events can meet at a window boundary. The reference update waits for the next first sample, while the comparison for the closing window happens on that window's last sample. The bench writes a new level in the middle of a window and in the idle gap before a window. It then checks that the closing result is judged against the old level and the following window against the new one. It also drives a window of full-scale negative samples, so that clamping and the result strobe fall in the same window. There it checks that the clamped result, the fault and the sticky overflow all appear together and that the overflow survives the next, ordinary window.

// File: rtl/msq_pkg.sv
package msq_pkg;

  // Where an accepted sample sits inside its window.
  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_MID   = 2'd1,
    PH_LAST  = 2'd2
  } win_phase_e;

endpackage

// File: rtl/msq_squarer.sv
module msq_squarer #(
  parameter int SAMPLE_W = 16,
  localparam int SQ_W = 2 * SAMPLE_W
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic        [SQ_W-1:0]     square
);

  logic signed [SQ_W-1:0] prod;

  // Signed product; the square of the most negative code still fits as a positive value.
  always_comb begin
    prod   = SQ_W'(sample) * SQ_W'(sample);
    square = $unsigned(prod);
  end

endmodule

// File: rtl/msq_win_ctr.sv
module msq_win_ctr #(
  parameter int WIN_LOG2 = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  output msq_pkg::win_phase_e    phase
);

  import msq_pkg::*;

  localparam logic [WIN_LOG2-1:0] LAST_IDX = '1;

  logic [WIN_LOG2-1:0] cnt_q, cnt_d;

  // Next-state: advance on each accepted sample; the power-of-two length wraps naturally.
  always_comb begin
    cnt_d = cnt_q;
    if (accept) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (cnt_q == '0)           phase = PH_FIRST;
    else if (cnt_q == LAST_IDX) phase = PH_LAST;
    else                       phase = PH_MID;
  end

  // R2: idle cycles leave the window position untouched
  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cnt_q));

  // R4: after the last sample the next one opens a fresh window
  a_r4_window_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && phase == PH_LAST) |=> (phase == PH_FIRST));

endmodule

// File: rtl/msq_sat_acc.sv
module msq_sat_acc #(
  parameter int SQ_W  = 32,
  parameter int ACC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  msq_pkg::win_phase_e  phase,
  input  logic [SQ_W-1:0]      square,
  output logic [ACC_W-1:0]     total,
  output logic                 ovf
);

  import msq_pkg::*;

  logic [ACC_W-1:0] acc_q, acc_d, sq_ext;
  logic [ACC_W:0]   raw_sum;
  logic             carry;
  logic             ovf_q, ovf_d;

  // Width adaptation of the square to the accumulator.
  generate
    if (ACC_W == SQ_W) begin : g_same_w
      assign sq_ext = square;
    end else begin : g_zero_ext
      assign sq_ext = {{(ACC_W - SQ_W){1'b0}}, square};
    end
  endgenerate

  // Next-state: a first sample loads, later samples add with a clamp at all ones.
  always_comb begin
    raw_sum = {1'b0, acc_q} + {1'b0, sq_ext};
    carry   = raw_sum[ACC_W];
    if (phase == PH_FIRST) total = sq_ext;
    else if (carry)        total = '1;
    else                   total = raw_sum[ACC_W-1:0];
    acc_d = accept ? total : acc_q;
    ovf_d = ovf_q | (accept && (phase != PH_FIRST) && carry);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign ovf = ovf_q;

  // R5: inside a window the running sum never falls (no wrap)
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && phase != PH_FIRST) |=> (acc_q >= $past(acc_q)));

  // R5: the overflow flag rises only with the sum pinned at its ceiling
  a_r5_clamped_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (acc_q == '1));

  // R6: overflow is sticky
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/msq_ref_cmp.sv
module msq_ref_cmp #(
  parameter int ACC_W    = 32,
  parameter int WIN_LOG2 = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_we,
  input  logic [ACC_W-1:0]     ref_level,
  input  logic                 accept,
  input  msq_pkg::win_phase_e  phase,
  input  logic [ACC_W-1:0]     total,
  output logic                 res_valid,
  output logic [ACC_W-1:0]     res_level,
  output logic                 res_fault
);

  import msq_pkg::*;

  logic [ACC_W-1:0] pend_q, pend_d;
  logic [ACC_W-1:0] act_q, act_d;
  logic [ACC_W-1:0] val_q, val_d;
  logic [ACC_W-1:0] mean_sq;
  logic             vld_q, vld_d;
  logic             flt_q, flt_d;
  logic             win_open, win_close;

  // Next-state: pending level from the write port, active level at window start,
  // result, strobe and fault at window end.
  always_comb begin
    win_open  = accept && (phase == PH_FIRST);
    win_close = accept && (phase == PH_LAST);
    mean_sq   = total >> WIN_LOG2;
    pend_d    = ref_we    ? ref_level : pend_q;
    act_d     = win_open  ? pend_q    : act_q;
    vld_d     = win_close;
    val_d     = win_close ? mean_sq   : val_q;
    flt_d     = win_close ? (mean_sq > act_q) : flt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      val_q  <= '0;
      vld_q  <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      val_q  <= val_d;
      vld_q  <= vld_d;
      flt_q  <= flt_d;
    end
  end

  assign res_valid = vld_q;
  assign res_level = val_q;
  assign res_fault = flt_q;

  // R3: the strobe lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R3: the result is held between strobes
  a_r3_value_held: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(val_q));

  // R7: the fault indication only moves together with a new result
  a_r7_fault_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q != $past(flt_q)) |-> vld_q);

  // R8: the level in force changes only when a window opens
  a_r8_ref_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(act_q));

endmodule

// File: rtl/msq_window_acc.sv
module msq_window_acc #(
  parameter int SAMPLE_W = 16,
  parameter int WIN_LOG2 = 8,
  parameter int ACC_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                ref_we,
  input  logic [ACC_W-1:0]    ref_level,
  output logic                res_valid,
  output logic [ACC_W-1:0]    res_level,
  output logic                res_fault,
  output logic                ovf_flag
);

  import msq_pkg::*;

  localparam int SQ_W = 2 * SAMPLE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              rdy_q, rdy_d;
  logic              accept;
  win_phase_e        phase;
  logic [SQ_W-1:0]   square;
  logic [ACC_W-1:0]  total;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  always_comb rdy_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rdy_q <= 1'b0;
    else          rdy_q <= rdy_d;
  end

  assign smp_ready = rdy_q;
  assign accept    = smp_valid && rdy_q;

  msq_squarer #(.SAMPLE_W(SAMPLE_W)) u_sq (
    .sample (smp_data),
    .square (square)
  );

  msq_win_ctr #(.WIN_LOG2(WIN_LOG2)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .accept (accept),
    .phase  (phase)
  );

  msq_sat_acc #(.SQ_W(SQ_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .accept (accept),
    .phase  (phase),
    .square (square),
    .total  (total),
    .ovf    (ovf_flag)
  );

  msq_ref_cmp #(.ACC_W(ACC_W), .WIN_LOG2(WIN_LOG2)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ref_we    (ref_we),
    .ref_level (ref_level),
    .accept    (accept),
    .phase     (phase),
    .total     (total),
    .res_valid (res_valid),
    .res_level (res_level),
    .res_fault (res_fault)
  );

  // R2: nothing is taken while not ready
  a_r2_no_take_unready: assert property (@(posedge clk) disable iff (!rst_n_i)
    !smp_ready |-> !accept);

endmodule

// File: tb/tb_msq_window_acc.sv
module tb_msq_window_acc;

  localparam int WIN = 256;
  localparam int NV  = 6;
  localparam int V_BASE  [NV] = '{0, 100, -300, 1000, -2000, 5};
  localparam int V_STEP  [NV] = '{0, 0, 3, -7, 16, 1};
  localparam int V_DELTA [NV] = '{0, -1, 1, 0, -1, 5};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic        smp_ready;
  logic [15:0] smp_data;
  logic        ref_we;
  logic [31:0] ref_level;
  logic        res_valid;
  logic [31:0] res_level;
  logic        res_fault;
  logic        ovf_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  msq_window_acc dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .ref_we    (ref_we),
    .ref_level (ref_level),
    .res_valid (res_valid),
    .res_level (res_level),
    .res_fault (res_fault),
    .ovf_flag  (ovf_flag)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint mean_of(input int b, input int st);
    longint t;
    logic signed [15:0] s;
    t = 0;
    for (int i = 0; i < WIN; i++) begin
      s = 16'(b + st * i);
      t += longint'(s) * longint'(s);
    end
    if (t > 64'hFFFF_FFFF) t = 64'hFFFF_FFFF;
    return t / WIN;
  endfunction

  task automatic write_ref(input longint v);
    ref_we    = 1'b1;
    ref_level = 32'(v);
    @(negedge clk);
    ref_we    = 1'b0;
  endtask

  // Leaves smp_valid high after the last sample; outputs of the closing edge are visible on return.
  task automatic run_window(input int b, input int st, input int gap_every,
                            input bit mid_wr, input longint mid_val);
    for (int i = 0; i < WIN; i++) begin
      smp_valid = 1'b1;
      smp_data  = 16'(b + st * i);
      if (mid_wr && i == 100) begin
        ref_we    = 1'b1;
        ref_level = 32'(mid_val);
      end else begin
        ref_we = 1'b0;
      end
      @(negedge clk);
      ref_we = 1'b0;
      if (gap_every > 0 && (i % gap_every) == gap_every - 1 && i != WIN - 1) begin
        smp_valid = 1'b0;
        smp_data  = 16'h7FFF;
        @(negedge clk);
      end
    end
  endtask

  task automatic idle_check_pulse(input string req);
    smp_valid = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, req, res_valid, 0);
  endtask

  task automatic wait_ready;
    while (!smp_ready) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    longint e, r;
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    ref_we    = 1'b0;
    ref_level = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(smp_ready == 1'b0, "R1 ready", smp_ready, 0);
    chk(res_valid == 1'b0, "R1 valid", res_valid, 0);
    chk(res_level == 32'd0, "R1 level", res_level, 0);
    chk(res_fault == 1'b0, "R1 fault", res_fault, 0);
    chk(ovf_flag == 1'b0, "R1 ovf", ovf_flag, 0);

    rst_n = 1'b1;
    wait_ready();
    chk(smp_ready == 1'b1, "R2 ready after reset", smp_ready, 1);

    // Table walk: R3 value and strobe, R7 comparison against a level near the result
    for (int v = 0; v < NV; v++) begin
      e = mean_of(V_BASE[v], V_STEP[v]);
      r = e + V_DELTA[v];
      write_ref(r);
      run_window(V_BASE[v], V_STEP[v], 0, 1'b0, 0);
      chk(res_valid == 1'b1, "R3 strobe", res_valid, 1);
      chk(res_level == 32'(e), "R3 level", res_level, e);
      chk(res_fault == (e > r), "R7 fault", res_fault, (e > r));
      idle_check_pulse("R3 single pulse");
      chk(res_level == 32'(e), "R3 level held", res_level, e);
    end

    // R2: idle cycles with junk data are ignored
    e = mean_of(77, 3);
    run_window(77, 3, 16, 1'b0, 0);
    chk(res_level == 32'(e), "R2 gaps ignored", res_level, e);
    idle_check_pulse("R2 pulse");

    // R4: two windows back to back
    run_window(500, 0, 0, 1'b0, 0);
    chk(res_level == 32'd250000, "R4 first window", res_level, 250000);
    run_window(0, 0, 0, 1'b0, 0);
    chk(res_level == 32'd0, "R4 second window fresh", res_level, 0);
    idle_check_pulse("R4 pulse");

    // R8: a mid-window write applies only to the next window
    write_ref(0);
    run_window(10, 0, 0, 1'b1, 1000);
    chk(res_fault == 1'b1, "R8 old level used", res_fault, 1);
    idle_check_pulse("R8 pulse");
    run_window(10, 0, 0, 1'b0, 0);
    chk(res_fault == 1'b0, "R8 new level used", res_fault, 0);
    idle_check_pulse("R8 pulse 2");

    // R5/R6: clamp at full scale
    chk(ovf_flag == 1'b0, "R6 clear before clamp", ovf_flag, 0);
    run_window(-32768, 0, 0, 1'b0, 0);
    chk(res_level == 32'h00FF_FFFF, "R5 clamped level", res_level, 32'h00FF_FFFF);
    chk(ovf_flag == 1'b1, "R6 ovf set", ovf_flag, 1);
    chk(res_fault == 1'b1, "R7 clamped over level", res_fault, 1);
    idle_check_pulse("R5 pulse");
    run_window(1, 0, 0, 1'b0, 0);
    chk(res_level == 32'd1, "R5 next window normal", res_level, 1);
    chk(ovf_flag == 1'b1, "R6 ovf sticky", ovf_flag, 1);
    idle_check_pulse("R6 pulse");

    // R9: reset in mid-window
    for (int i = 0; i < 100; i++) begin
      smp_valid = 1'b1;
      smp_data  = 16'd1000;
      @(negedge clk);
    end
    smp_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R1 ovf cleared by reset", ovf_flag, 0);
    chk(res_level == 32'd0, "R1 level cleared by reset", res_level, 0);
    rst_n = 1'b1;
    wait_ready();
    run_window(2, 0, 0, 1'b0, 0);
    chk(res_level == 32'd4, "R9 partial discarded", res_level, 4);
    chk(res_fault == 1'b1, "R1 level reset to zero", res_fault, 1);
    idle_check_pulse("R9 pulse");

    finish_run();
  end

endmodule